// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a 32-bit down-counter behind a small register bus (address, write enable, write data, combinational read data). A programmable 8-bit divider sits between the clock and the counter. In timer mode, the counter reaching zero raises an event flag, which can drive an interrupt line. The counter can also restart by itself from a reload value.

In watchdog mode, the counter reaching zero raises a separate reset-status flag and drives a reset-request output. That output stays high until software clears the flag. Software can turn watchdog mode on with an ordinary control write. It can only turn it off with two unlock words, written one after the other to a dedicated register.

Top module: `guarded_wdog`

Register offsets (byte addresses): 0x00 reload value, 0x04 live count, 0x08 control, 0x0C timer event flag, 0x10 watchdog reset flag, 0x14 unlock register (reads as 0). Control layout: bit 0 run, bit 1 auto-restart, bit 2 interrupt enable, bit 3 watchdog mode, bits 15:8 divider value. All other bits read as 0.

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and both `irq` and `rst_req` are low.
- R2: A write to offset 0x00 stores the reload value and copies it into the live count on the same clock edge. The live count is readable at offset 0x04.
- R3: With the run bit (control bit 0) set, the count drops by one every (divider + 1) clocks, counted from the last reload-value write. With the run bit clear, the count holds.
- R4: In timer mode, a decrement from 1 to 0 sets bit 0 at offset 0x0C. Without auto-restart, the count then stays at 0.
- R5: In timer mode with auto-restart (control bit 1) set, the first divided tick after the count reaches 0 reloads it from the reload value.
- R6: `irq` is high exactly when the timer event flag is set and the interrupt enable (control bit 2) is set.
- R7: Writing 1 to bit 0 of offset 0x0C or 0x10 clears that flag. Writing 0 leaves it unchanged. A new expiry in the same cycle wins over the clear.
- R8: In watchdog mode (control bit 3 set), a decrement from 1 to 0 sets bit 0 at offset 0x10 and raises `rst_req`, without touching the timer flag. `rst_req` stays high until that flag is cleared.
- R9: A control write can set the watchdog mode bit. A control write with bit 3 equal to 0 leaves the mode bit unchanged.
- R10: The mode bit clears only when 0x87654321 is written to offset 0x14 and the bus write just before it was 0x12345678 to offset 0x14. Any other write breaks the pairing. A write of 0x12345678 always starts a new pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Timer interrupt request |
| rst_req | output | 1 | Watchdog reset request |

## Verification
A wrong divider phase or a wrong decrement shows up in the count at offset 0x04, one clock after the faulty tick. So the bench samples the count after a known number of edges for several divider values. A flag set or cleared on the wrong edge, or a restart that loads the wrong value, appears on `irq`, `rst_req` or the flag registers on the clock following the expiry. A broken unlock tracker shows up at the next read of control bit 3, after each correct, wrong or interrupted unlock sequence.

// File: rtl/wdog_pkg.sv
// Package: shared constants and control layout of the guarded watchdog timer.
// Assumes a 32-bit data bus and byte addresses fitting in five bits.
package wdog_pkg;

    localparam int DIV_W = 8;

    // Byte offsets of the software-visible registers
    localparam int OFF_RELOAD = 'h00;
    localparam int OFF_COUNT  = 'h04;
    localparam int OFF_CTRL   = 'h08;
    localparam int OFF_TFLAG  = 'h0C;
    localparam int OFF_WFLAG  = 'h10;
    localparam int OFF_UNLOCK = 'h14;

    // Unlock words, first then second
    localparam logic [31:0] KEY_FIRST  = 32'h1234_5678;
    localparam logic [31:0] KEY_SECOND = 32'h8765_4321;

    // Control bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_AUTO = 1;
    localparam int CB_IEN  = 2;
    localparam int CB_WDOG = 3;
    localparam int CB_DIV  = 8;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             wdog;
        logic             ien;
        logic             auto_rl;
        logic             run;
    } ctrl_t;

endpackage

// File: rtl/wdog_prescale.sv
// Module: clock divider producing a one-cycle tick every (div + 1) enabled clocks.
// Assumes: restart clears the phase so the first tick comes div + 1 clocks later.
module wdog_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    // Tick when the phase has reached the divider value
    assign tick = en && !restart && (phase_q >= div);

    // Advance the phase, wrapping on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            phase_q <= '0;
        end else if (phase_q >= div) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    AST_TICK_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |-> $past(en) && !$past(restart)) else $error("tick without prior run"); // R3

endmodule

// File: rtl/wdog_count.sv
// Module: down-counter with immediate load, expiry pulse and optional reload at zero.
// Assumes: load has priority over a tick in the same cycle.
module wdog_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_data,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign count  = cnt_q;
    // Expiry is the tick that takes the count from one to zero
    assign expire = tick && !load_we && (cnt_q == ONE);

    // Update the count: load, reload at zero, or decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_we) begin
            cnt_q <= load_data;
        end else if (tick) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - ONE;
            end else if (reload_en) begin
                cnt_q <= reload_val;
            end
        end
    end

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> cnt_q == $past(load_data)) else $error("load not copied"); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_we) |=> $stable(cnt_q)) else $error("count moved without tick"); // R3
    AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt_q == '0) else $error("expiry did not reach zero"); // R4
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we && cnt_q == '0 && reload_en) |=> cnt_q == $past(reload_val)) else $error("reload wrong"); // R5

endmodule

// File: rtl/wdog_unlock.sv
// Module: tracks the two-word sequence that releases watchdog mode.
// Assumes: at most one bus write per cycle; other_we marks writes to other offsets.
module wdog_unlock #(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY_A  = 32'h1234_5678,
    parameter logic [31:0] KEY_B  = 32'h8765_4321
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dis_we,
    input  logic              other_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlock
);

    logic armed_q;

    // Second word accepted only straight after the first
    assign unlock = dis_we && armed_q && (wdata == DATA_W'(KEY_B));

    // Arm on the first word, disarm on any other write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (dis_we) begin
            armed_q <= (wdata == DATA_W'(KEY_A));
        end else if (other_we) begin
            armed_q <= 1'b0;
        end
    end

    AST_UNLOCK_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> !armed_q) else $error("sequence left armed"); // R10
    AST_OTHER_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        other_we |=> !unlock) else $error("unlock after foreign write"); // R10

endmodule

// File: rtl/guarded_wdog.sv
// Module: top of the dual-mode timer / watchdog with guarded mode release.
// Assumes: one bus write per cycle, combinational reads, DATA_W of at least 16.
module guarded_wdog #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    import wdog_pkg::*;

    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_TFLAG  = ADDR_W'(OFF_TFLAG);
    localparam logic [ADDR_W-1:0] A_WFLAG  = ADDR_W'(OFF_WFLAG);
    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);

    ctrl_t             ctrl_q;
    logic              tflag_q, wflag_q;
    logic              we_reload, we_ctrl, we_tflag, we_wflag, we_unlock;
    logic              tick, expire, unlock;
    logic [DATA_W-1:0] reload_q, count;

    // Decode write strobes per register
    always_comb begin
        we_reload = bus_we && (bus_addr == A_RELOAD);
        we_ctrl   = bus_we && (bus_addr == A_CTRL);
        we_tflag  = bus_we && (bus_addr == A_TFLAG);
        we_wflag  = bus_we && (bus_addr == A_WFLAG);
        we_unlock = bus_we && (bus_addr == A_UNLOCK);
    end

    // Hold the reload value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (we_reload) begin
            reload_q <= bus_wdata;
        end
    end

    // Control register; watchdog mode set by write, cleared only by unlock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we_ctrl) begin
            ctrl_q.div     <= bus_wdata[CB_DIV +: DIV_W];
            ctrl_q.ien     <= bus_wdata[CB_IEN];
            ctrl_q.auto_rl <= bus_wdata[CB_AUTO];
            ctrl_q.run     <= bus_wdata[CB_RUN];
            ctrl_q.wdog    <= ctrl_q.wdog | bus_wdata[CB_WDOG];
        end else if (unlock) begin
            ctrl_q.wdog    <= 1'b0;
        end
    end

    // Timer event flag: expiry sets, write-one clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tflag_q <= 1'b0;
        end else if (expire && !ctrl_q.wdog) begin
            tflag_q <= 1'b1;
        end else if (we_tflag && bus_wdata[0]) begin
            tflag_q <= 1'b0;
        end
    end

    // Watchdog reset flag: expiry sets, write-one clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wflag_q <= 1'b0;
        end else if (expire && ctrl_q.wdog) begin
            wflag_q <= 1'b1;
        end else if (we_wflag && bus_wdata[0]) begin
            wflag_q <= 1'b0;
        end
    end

    wdog_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q.run),
        .restart (we_reload),
        .div     (ctrl_q.div),
        .tick    (tick)
    );

    wdog_count #(.CNT_W(DATA_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_we    (we_reload),
        .load_data  (bus_wdata),
        .reload_en  (ctrl_q.auto_rl && !ctrl_q.wdog),
        .reload_val (reload_q),
        .count      (count),
        .expire     (expire)
    );

    wdog_unlock #(.DATA_W(DATA_W), .KEY_A(KEY_FIRST), .KEY_B(KEY_SECOND)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_we   (we_unlock),
        .other_we (bus_we && !we_unlock),
        .wdata    (bus_wdata),
        .unlock   (unlock)
    );

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_RELOAD: bus_rdata = reload_q;
            A_COUNT:  bus_rdata = count;
            A_CTRL: begin
                bus_rdata[CB_DIV +: DIV_W] = ctrl_q.div;
                bus_rdata[CB_WDOG]         = ctrl_q.wdog;
                bus_rdata[CB_IEN]          = ctrl_q.ien;
                bus_rdata[CB_AUTO]         = ctrl_q.auto_rl;
                bus_rdata[CB_RUN]          = ctrl_q.run;
            end
            A_TFLAG:  bus_rdata[0] = tflag_q;
            A_WFLAG:  bus_rdata[0] = wflag_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq     = tflag_q & ctrl_q.ien;
    assign rst_req = wflag_q;

    AST_TIMER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl_q.wdog) |=> tflag_q) else $error("timer flag missed"); // R4
    AST_WDOG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_q.wdog) |=> rst_req && $stable(tflag_q)) else $error("watchdog flag missed"); // R8
    AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (we_ctrl && ctrl_q.wdog) |=> ctrl_q.wdog) else $error("mode cleared by control write"); // R9
    AST_UNLOCK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.wdog) |-> (!$past(rst_n) || $past(we_unlock && bus_wdata == DATA_W'(KEY_SECOND))))
        else $error("mode left without unlock"); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !(we_wflag && bus_wdata[0])) |=> rst_req) else $error("request dropped"); // R8

endmodule

// File: tb/guarded_wdog_bench.sv
module guarded_wdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    // Vector table: divider, reload value, edges to wait, expected count, expected timer flag
    localparam int          V_DIV  [NV] = '{0, 3, 1, 255, 0};
    localparam logic [31:0] V_LOAD [NV] = '{32'd100, 32'd100, 32'd50, 32'd5, 32'd3};
    localparam int          V_WAIT [NV] = '{10, 10, 7, 300, 5};
    localparam logic [31:0] V_CNT  [NV] = '{32'd90, 32'd98, 32'd47, 32'd4, 32'd0};
    localparam logic        V_FLAG [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    guarded_wdog u_guarded_wdog (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        edges(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(5'h08, v); chk("R1 control", v, 0);
        rd(5'h04, v); chk("R1 count", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);

        // Table walk: R3 divider, R4 expiry, R6 irq
        for (int k = 0; k < NV; k++) begin
            wr(5'h0C, 32'h1);
            wr(5'h08, (32'(V_DIV[k]) << 8) | 32'h5);
            wr(5'h00, V_LOAD[k]);
            edges(V_WAIT[k]);
            rd(5'h04, v); chk("R3 count after divided ticks", v, V_CNT[k]);
            rd(5'h0C, v); chk("R4 timer flag", v, {31'b0, V_FLAG[k]});
            chk("R6 irq follows flag", {31'b0, irq}, {31'b0, V_FLAG[k]});
        end

        // R5 auto-restart
        wr(5'h0C, 32'h1);
        wr(5'h08, 32'h7);
        wr(5'h00, 32'd4);
        edges(4);
        rd(5'h04, v); chk("R4 reaches zero", v, 0);
        rd(5'h0C, v); chk("R4 flag at zero", v, 1);
        edges(1);
        rd(5'h04, v); chk("R5 reloaded", v, 4);

        // R6 mask, R7 write-one-clear
        wr(5'h08, 32'h2);
        chk("R6 irq masked", {31'b0, irq}, 0);
        rd(5'h0C, v); chk("R6 flag kept", v, 1);
        wr(5'h08, 32'h4);
        chk("R6 irq unmasked", {31'b0, irq}, 1);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v); chk("R7 zero write ignored", v, 1);
        wr(5'h0C, 32'h1);
        rd(5'h0C, v); chk("R7 flag cleared", v, 0);
        chk("R7 irq cleared", {31'b0, irq}, 0);

        // R2 immediate load, R3 hold while stopped
        wr(5'h00, 32'h1234_ABCD);
        rd(5'h04, v); chk("R2 load copied", v, 32'h1234_ABCD);
        edges(10);
        rd(5'h04, v2); chk("R3 hold when stopped", v2, 32'h1234_ABCD);

        // R8 watchdog expiry
        wr(5'h08, 32'h9);
        wr(5'h00, 32'd3);
        edges(3);
        chk("R8 rst_req", {31'b0, rst_req}, 1);
        rd(5'h10, v); chk("R8 reset flag", v, 1);
        rd(5'h0C, v); chk("R8 timer flag untouched", v, 0);
        // R9 clearing write ignored
        wr(5'h08, 32'h1);
        rd(5'h08, v); chk("R9 mode kept", v, 32'h9);
        edges(5);
        chk("R8 rst_req held", {31'b0, rst_req}, 1);
        wr(5'h10, 32'h1);
        chk("R8 rst_req released", {31'b0, rst_req}, 0);
        wr(5'h08, 32'h8);

        // R10 unlock sequence
        wr(5'h14, 32'h8765_4321);
        rd(5'h08, v); chk("R10 second word alone", v, 32'h8);
        wr(5'h14, 32'h1234_5678);
        wr(5'h14, 32'h0BAD_F00D);
        wr(5'h14, 32'h8765_4321);
        rd(5'h08, v); chk("R10 wrong middle word", v, 32'h8);
        wr(5'h14, 32'h1234_5678);
        wr(5'h00, 32'd9);
        wr(5'h14, 32'h8765_4321);
        rd(5'h08, v); chk("R10 foreign write between", v, 32'h8);
        wr(5'h14, 32'h1234_5678);
        wr(5'h14, 32'h1234_5678);
        wr(5'h14, 32'h8765_4321);
        rd(5'h08, v); chk("R10 released after re-arm", v, 32'h0);

        // R1 reset in the middle of a watchdog run
        wr(5'h08, 32'h9);
        wr(5'h00, 32'd7);
        @(negedge clk); rst_n = 1'b0;
        edges(2);
        rst_n = 1'b1;
        @(negedge clk);
        rd(5'h08, v); chk("R1 control after reset", v, 0);
        rd(5'h00, v); chk("R1 reload after reset", v, 0);
        rd(5'h04, v); chk("R1 count after reset", v, 0);
        chk("R1 outputs after reset", {30'b0, irq, rst_req}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule